// File: doc/BRIEF.md
# I2C Start/Stop Condition Generator

This block drives the two open-drain lines of an I2C bus master while it creates a START or a STOP condition. Software, or a neighbouring controller, writes a status word that holds three control bits: master, transmit and bus-busy. The write takes effect only while the interface enable input is high. Master and transmit both at 1 with bus-busy at 1 asks for a START. Master and transmit both at 1 with bus-busy at 0 asks for a STOP.

Every interval is counted in system clock cycles. One set of counts applies in standard mode and a shorter set applies in high-speed mode. The mode is captured on the cycle the request is accepted. The bus-busy flag changes a fixed number of cycles after the accepted write. At the end of a START the block clears the bit counter and pulses a byte-start strobe, so that a separate shifter can begin clocking the first byte. The line outputs are pull-down enables: 1 drives the line low and 0 releases it.

Top module: `i2c_cond_gen`

## Requirements
- R1: After a synchronous reset, scl_pull, sda_pull, bus_busy, byte_go, seq_active and bit_cnt are all 0.
- R2: While idle with if_en=1, a cycle with sr_wr=1, sr_mst=1, sr_trx=1 and sr_busy=1 starts a START sequence, and seq_active is 1 from the next cycle on.
- R3: In standard mode (hs_mode=0) a START drives sda_pull to 1 twenty cycles after the write edge, while scl_pull stays 0. It then drives scl_pull to 1 twenty cycles after that, which is cycle 40.
- R4: In high-speed mode (hs_mode=1) a START drives sda_pull to 1 at cycle 10 and scl_pull to 1 at cycle 20 after the write edge.
- R5: While idle with if_en=1, a write with sr_mst=1, sr_trx=1 and sr_busy=0 starts a STOP. From the next cycle scl_pull is 0 and sda_pull is 1. sda_pull returns to 0 at cycle 17 in standard mode or cycle 7 in high-speed mode, and the sequence ends on that same cycle.
- R6: bus_busy becomes 1 at cycle 12 (standard) or cycle 6 (high-speed) after a START write edge. It becomes 0 at the same offsets after a STOP write edge.
- R7: Each cycle with bit_tick=1 advances bit_cnt by one, wrapping from 7 to 0. On the cycle a START ends, bit_cnt becomes 0 and byte_go is 1 for exactly one cycle.
- R8: A status write while if_en=0 is ignored. No line, flag or sequence output changes.
- R9: A write that arrives while a sequence is running is ignored. A write that asks for neither condition (sr_mst=0 or sr_trx=0) is also ignored.
- R10: hs_mode is sampled when a request is accepted. Changing it during the sequence does not change that sequence's timing.
- R11: sda_pull changes only while scl_pull is 0, and scl_pull becomes 1 only while sda_pull is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every interval is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Interface enable; status writes act only while 1 |
| hs_mode | input | 1 | 1 selects high-speed counts, 0 selects standard counts |
| sr_wr | input | 1 | Status write strobe, one cycle |
| sr_mst | input | 1 | Master bit of the written status word |
| sr_trx | input | 1 | Transmit bit of the written status word |
| sr_busy | input | 1 | Bus-busy bit of the written status word |
| bit_tick | input | 1 | Advances the bit counter by one |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| bus_busy | output | 1 | Bus-busy flag |
| bit_cnt | output | 3 | Bit counter |
| byte_go | output | 1 | One-cycle strobe when a START completes |
| seq_active | output | 1 | 1 while a START or STOP sequence runs |

## Verification
The bench samples each line and the busy flag one cycle before and one cycle on its expected edge in both modes. A counter that is off by one therefore shows up as an early or late transition. It flips hs_mode straight after a high-speed START is accepted and sends a STOP in the middle of that START. A design that reads the mode live would stretch the sequence to standard counts, and a design without the idle guard would release SDA during the START. Writes with the enable low and malformed control bits are checked over thirty cycles; a missing gate would raise seq_active or move the lines. The bit counter is driven past its wrap point and then cleared by a START, which exposes a wrong modulus or a clear that never takes effect.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_STOP  = 2'd2
  } seq_t;

  typedef struct packed {
    logic start_req;
    logic stop_req;
  } req_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // The mode bits are only looked at when master and transmit are both set.
  function automatic req_t decode_req(input logic en, input logic wr,
                                      input logic mst, input logic trx,
                                      input logic busy);
    req_t r;
    r.start_req = en & wr & mst & trx & busy;
    r.stop_req  = en & wr & mst & trx & ~busy;
    return r;
  endfunction

endpackage

// File: rtl/i2c_cond_timing.sv
module i2c_cond_timing #(
  parameter int CW           = 6,
  parameter int STD_SU_START = 20,
  parameter int STD_SU_STOP  = 17,
  parameter int STD_HOLD     = 20,
  parameter int STD_BB       = 12,
  parameter int HS_SU_START  = 10,
  parameter int HS_SU_STOP   = 7,
  parameter int HS_HOLD      = 10,
  parameter int HS_BB        = 6
) (
  input  logic          hs_q,
  output logic [CW-1:0] su_start,
  output logic [CW-1:0] su_stop,
  output logic [CW-1:0] start_end,
  output logic [CW-1:0] bb_dly
);

  localparam logic [CW-1:0] STD_END = CW'(STD_SU_START + STD_HOLD);
  localparam logic [CW-1:0] HS_END  = CW'(HS_SU_START + HS_HOLD);

  always_comb begin
    if (hs_q) begin
      su_start  = CW'(HS_SU_START);
      su_stop   = CW'(HS_SU_STOP);
      start_end = HS_END;
      bb_dly    = CW'(HS_BB);
    end else begin
      su_start  = CW'(STD_SU_START);
      su_stop   = CW'(STD_SU_STOP);
      start_end = STD_END;
      bb_dly    = CW'(STD_BB);
    end
  end

endmodule

// File: rtl/i2c_cond_elapsed.sv
module i2c_cond_elapsed #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  output logic [CW-1:0] cnt
);

  // Loading 1 makes cnt equal k during the cycle that ends at edge k after acceptance.
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= CW'(1);
    else if (run)  cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int STD_SU_START  = 20,
  parameter int STD_SU_STOP   = 17,
  parameter int STD_HOLD      = 20,
  parameter int STD_BB        = 12,
  parameter int HS_SU_START   = 10,
  parameter int HS_SU_STOP    = 7,
  parameter int HS_HOLD       = 10,
  parameter int HS_BB         = 6,
  parameter int BITS_PER_BYTE = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       if_en,
  input  logic       hs_mode,
  input  logic       sr_wr,
  input  logic       sr_mst,
  input  logic       sr_trx,
  input  logic       sr_busy,
  input  logic       bit_tick,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       bus_busy,
  output logic [2:0] bit_cnt,
  output logic       byte_go,
  output logic       seq_active
);

  localparam int BCW  = $clog2(BITS_PER_BYTE);
  localparam int SPAN = imax(imax(STD_SU_START + STD_HOLD, STD_SU_STOP),
                             imax(HS_SU_START + HS_HOLD, HS_SU_STOP));
  localparam int CW   = $clog2(imax(SPAN, imax(STD_BB, HS_BB)) + 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BITS_PER_BYTE - 1);

  seq_t          st;
  logic          hs_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] su_start, su_stop, start_end, bb_dly;
  logic [BCW-1:0] bits_q;
  req_t          req;
  logic          take_start, take_stop;

  assign req        = decode_req(if_en, sr_wr, sr_mst, sr_trx, sr_busy);
  assign take_start = (st == ST_IDLE) && req.start_req;
  assign take_stop  = (st == ST_IDLE) && req.stop_req;
  assign seq_active = (st != ST_IDLE);
  assign bit_cnt    = 3'(bits_q);

  i2c_cond_timing #(
    .CW(CW),
    .STD_SU_START(STD_SU_START), .STD_SU_STOP(STD_SU_STOP),
    .STD_HOLD(STD_HOLD),         .STD_BB(STD_BB),
    .HS_SU_START(HS_SU_START),   .HS_SU_STOP(HS_SU_STOP),
    .HS_HOLD(HS_HOLD),           .HS_BB(HS_BB)
  ) u_timing (
    .hs_q     (hs_q),
    .su_start (su_start),
    .su_stop  (su_stop),
    .start_end(start_end),
    .bb_dly   (bb_dly)
  );

  i2c_cond_elapsed #(.CW(CW)) u_elapsed (
    .clk (clk),
    .rst (rst),
    .load(take_start | take_stop),
    .run (seq_active),
    .cnt (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      hs_q     <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      bus_busy <= 1'b0;
      bits_q   <= '0;
      byte_go  <= 1'b0;
    end else begin
      byte_go <= 1'b0;
      if (bit_tick)
        bits_q <= (bits_q == BIT_LAST) ? '0 : bits_q + BCW'(1);

      unique case (st)
        ST_IDLE: begin
          if (take_start) begin
            st   <= ST_START;
            hs_q <= hs_mode;
          end else if (take_stop) begin
            st       <= ST_STOP;
            hs_q     <= hs_mode;
            scl_pull <= 1'b0;
            sda_pull <= 1'b1;
          end
        end
        ST_START: begin
          if (cnt == bb_dly)   bus_busy <= 1'b1;
          if (cnt == su_start) sda_pull <= 1'b1;
          if (cnt == start_end) begin
            scl_pull <= 1'b1;
            bits_q   <= '0;
            byte_go  <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_STOP: begin
          if (cnt == bb_dly) bus_busy <= 1'b0;
          if (cnt == su_stop) begin
            sda_pull <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       if_en,
  input logic       sr_wr,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       bus_busy,
  input logic [2:0] bit_cnt,
  input logic       byte_go,
  input logic       seq_active
);

  // R11: SDA may fall while SCL is released.
  a_r11_sda_fall_scl_free: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_pull);

  // R11: SDA may rise while SCL is released.
  a_r11_sda_rise_scl_free: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> !scl_pull);

  // R3: SCL is pulled low only after SDA is already low.
  a_r3_scl_after_sda: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> (sda_pull && $past(sda_pull)));

  // R8: a write with the enable low starts nothing.
  a_r8_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
    (!seq_active && sr_wr && !if_en) |=> !seq_active);

  // R6: the busy flag moves only inside a sequence.
  a_r6_busy_in_seq: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_busy) || $fell(bus_busy)) |-> seq_active);

  // R7: the byte strobe comes with a cleared counter and a finished sequence.
  a_r7_go_clears: assert property (@(posedge clk) disable iff (rst)
    byte_go |-> (bit_cnt == 3'd0 && !seq_active));

  // R7: the byte strobe lasts one cycle.
  a_r7_go_single: assert property (@(posedge clk) disable iff (rst)
    byte_go |=> !byte_go);

endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .if_en     (if_en),
  .sr_wr     (sr_wr),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull),
  .bus_busy  (bus_busy),
  .bit_cnt   (bit_cnt),
  .byte_go   (byte_go),
  .seq_active(seq_active)
);

// File: tb/i2c_cond_gen_bench.sv
`timescale 1ns/1ps
module i2c_cond_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       if_en = 1'b0, hs_mode = 1'b0;
  logic       sr_wr = 1'b0, sr_mst = 1'b0, sr_trx = 1'b0, sr_busy = 1'b0;
  logic       bit_tick = 1'b0;
  logic       scl_pull, sda_pull, bus_busy, byte_go, seq_active;
  logic [2:0] bit_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  i2c_cond_gen u_i2c_cond_gen (
    .clk(clk), .rst(rst), .if_en(if_en), .hs_mode(hs_mode),
    .sr_wr(sr_wr), .sr_mst(sr_mst), .sr_trx(sr_trx), .sr_busy(sr_busy),
    .bit_tick(bit_tick), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .bus_busy(bus_busy), .bit_cnt(bit_cnt), .byte_go(byte_go),
    .seq_active(seq_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Starts and ends on a negedge; on return the write edge has just passed.
  task automatic sr_write(input logic en, input logic m, input logic t, input logic b);
    if_en = en; sr_mst = m; sr_trx = t; sr_busy = b; sr_wr = 1'b1;
    @(negedge clk);
    sr_wr = 1'b0; if_en = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 bus_busy", bus_busy, 0);
    chk("R1 byte_go", byte_go, 0);
    chk("R1 seq_active", seq_active, 0);
    chk("R1 bit_cnt", bit_cnt, 0);
  endtask

  task automatic t_start_std();
    hs_mode = 1'b0;
    for (int i = 0; i < 9; i++) begin
      bit_tick = 1'b1; @(negedge clk);
      bit_tick = 1'b0; @(negedge clk);
    end
    chk("R7 bit_cnt wrap", bit_cnt, 1);
    sr_write(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2 seq_active", seq_active, 1);
    step(11); chk("R6 busy before 12", bus_busy, 0);
    step(1);  chk("R6 busy at 12", bus_busy, 1);
    step(7);  chk("R3 sda before 20", sda_pull, 0);
    step(1);  chk("R3 sda at 20", sda_pull, 1);
              chk("R3 scl held at 20", scl_pull, 0);
    step(19); chk("R3 scl before 40", scl_pull, 0);
              chk("R7 bit_cnt kept", bit_cnt, 1);
    step(1);  chk("R3 scl at 40", scl_pull, 1);
              chk("R7 bit_cnt cleared", bit_cnt, 0);
              chk("R7 byte_go", byte_go, 1);
              chk("R2 seq done", seq_active, 0);
    step(1);  chk("R7 byte_go one cycle", byte_go, 0);
  endtask

  task automatic t_stop_std();
    hs_mode = 1'b0;
    sr_write(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5 scl released", scl_pull, 0);
    chk("R5 sda held", sda_pull, 1);
    step(11); chk("R6 busy before 12", bus_busy, 1);
    step(1);  chk("R6 busy clear at 12", bus_busy, 0);
    step(4);  chk("R5 sda before 17", sda_pull, 1);
    step(1);  chk("R5 sda at 17", sda_pull, 0);
              chk("R5 seq done", seq_active, 0);
  endtask

  task automatic t_start_hs();
    hs_mode = 1'b1;
    sr_write(1'b1, 1'b1, 1'b1, 1'b1);
    hs_mode = 1'b0;                       // R10: mode change after acceptance
    step(2);
    sr_write(1'b1, 1'b1, 1'b1, 1'b0);     // R9: STOP during START, now at cycle 3
    step(2);  chk("R6 hs busy before 6", bus_busy, 0);
    step(1);  chk("R6 hs busy at 6", bus_busy, 1);
    step(3);  chk("R10 sda before 10", sda_pull, 0);
    step(1);  chk("R4 sda at 10", sda_pull, 1);
    step(9);  chk("R4 scl before 20", scl_pull, 0);
    step(1);  chk("R4 scl at 20", scl_pull, 1);
              chk("R10 seq done at 20", seq_active, 0);
    step(3);  chk("R9 rogue stop dropped sda", sda_pull, 1);
              chk("R9 rogue stop no seq", seq_active, 0);
  endtask

  task automatic t_stop_hs();
    hs_mode = 1'b1;
    sr_write(1'b1, 1'b1, 1'b1, 1'b0);
    step(5);  chk("R6 hs busy before 6", bus_busy, 1);
    step(1);  chk("R6 hs busy clear at 6", bus_busy, 0);
              chk("R5 hs sda at 6", sda_pull, 1);
    step(1);  chk("R5 hs sda at 7", sda_pull, 0);
              chk("R5 hs seq done", seq_active, 0);
    hs_mode = 1'b0;
  endtask

  task automatic quiet_window(input string tag);
    int moved = 0;
    for (int i = 0; i < 30; i++) begin
      if (seq_active || bus_busy || sda_pull || scl_pull || byte_go) moved++;
      @(negedge clk);
    end
    chk(tag, moved, 0);
  endtask

  task automatic t_ignored();
    sr_write(1'b0, 1'b1, 1'b1, 1'b1);
    quiet_window("R8 disabled write");
    sr_write(1'b1, 1'b0, 1'b1, 1'b1);
    quiet_window("R9 master bit clear");
    sr_write(1'b1, 1'b1, 1'b0, 1'b1);
    quiet_window("R9 transmit bit clear");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_start_std();
    t_stop_std();
    t_start_hs();
    t_stop_hs();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule